// File: doc/BRIEF.md
# Copy Request Segmenter and Queue

This block sits in front of a single memory-to-memory copy engine and serves several virtual requesters. Each copy request carries a source address, a destination address, a byte count, a tag and the number of the requester that issued it. The block cuts every request into segments no longer than the engine's maximum transfer size. It places the segments in one shared queue and feeds them to the engine one at a time, using a simple start/done handshake. The engine's data movement is outside the block.

Each accepted request holds a parent slot. The slot keeps a byte residue that starts at the full request length and falls by a segment's length each time the engine finishes that segment. Only the parent's completion is reported outward: one pulse carrying its tag, and only when the residue reaches zero. A tag-keyed query returns the residue of a request still in flight. A per-requester activity vector, together with a drain handshake, lets software wait until one requester has nothing left in the queue.

Requests arrive over a valid/ready stream. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and every payload field steady until that edge. `req_ready` does not depend on `req_valid`. It drops while the previous request is still being cut into segments, and the cutting stalls while the queue is full. It also drops while every parent slot is in use. The completion pulse and the drain acknowledge are plain outputs with no back-pressure.

Top module: `cq_segmenter`

## Requirements
- R1: A request transfers only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after an acceptance until the last segment of that request has entered the queue; segment entry stalls while the queue holds QDEPTH segments. `req_ready` is also low while all PSLOTS parent slots hold requests that have not completed.
- R2: A request of length L becomes ceil(L/MAX_SEG) segments, and a zero-length request becomes one segment of length 0. Segment k has length min(L - k*MAX_SEG, MAX_SEG). Its source and destination are the request's source and destination plus k*MAX_SEG.
- R3: In the cycle after acceptance, `qry_tag` equal to the request's tag gives `qry_hit`=1 and `qry_residue`=L. Each finished segment lowers the residue by that segment's length, visible in the cycle after the done. Once the parent completes, the query misses.
- R4: `cpl_valid` is high for exactly one cycle with the parent's tag and requester number. This happens in the cycle after the done that brings the residue to zero, and never for an earlier segment.
- R5: `eng_start` is high for one cycle, presenting the head segment's source, destination and length, whenever the queue is non-empty and no segment is in the engine. A segment entering an empty queue is started in the next cycle.
- R6: On `eng_done` the head segment leaves the queue. If another segment is queued, `eng_start` is high in the next cycle.
- R7: Segments are started strictly in acceptance order across all requesters. All segments of one request start before any segment of a later request.
- R8: `active[r]` is high while requester r has a segment in the queue or in the engine, or has a request still being segmented, and low otherwise.
- R9: A `drain_valid` pulse with `drain_id` records one pending drain, replacing any earlier pending one. `drain_ack` pulses for one cycle in the cycle after the recorded requester is observed inactive.
- R10: After reset `req_ready`=1, and `eng_start`, `cpl_valid`, `qry_hit`, `drain_ack` and `active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_src | input | ADDR_W | Request source address |
| req_dst | input | ADDR_W | Request destination address |
| req_len | input | LEN_W | Request byte count |
| req_tag | input | TAG_W | Request tag, returned on completion |
| req_id | input | clog2(NREQ) | Issuing requester |
| eng_start | output | 1 | Start the engine on the presented segment |
| eng_src | output | ADDR_W | Head segment source |
| eng_dst | output | ADDR_W | Head segment destination |
| eng_len | output | LEN_W | Head segment length |
| eng_done | input | 1 | Engine finished the started segment (one-cycle pulse) |
| cpl_valid | output | 1 | Parent request complete (one-cycle pulse) |
| cpl_tag | output | TAG_W | Tag of the completed request |
| cpl_id | output | clog2(NREQ) | Requester of the completed request |
| qry_tag | input | TAG_W | Tag to look up |
| qry_hit | output | 1 | An in-flight request has this tag |
| qry_residue | output | LEN_W | Bytes not yet copied for that request |
| drain_valid | input | 1 | Record a drain for `drain_id` |
| drain_id | input | clog2(NREQ) | Requester to drain |
| drain_ack | output | 1 | Recorded requester has gone idle (one-cycle pulse) |
| active | output | NREQ | Per-requester activity |

## Verification
The bench builds the block with MAX_SEG=5, an 8-bit length, a 4-entry queue, 2 parent slots and 4 requesters. With these values, requests of 0 to 23 bytes span zero-length, exact-multiple and remainder cases. They produce up to five segments, which overruns the queue and so exercises back-pressure. Two small requests fill every parent slot. The full length sweep runs against an engine model with varying latency. Each start's fields and each completion's position are compared against arithmetic predictions. Directed runs with a manually pulsed engine step through residue values, drain timing and launch order.

// File: rtl/cq_splitter.sv
module cq_splitter #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 32,
  parameter int ID_W    = 2,
  parameter int PIDX_W  = 2,
  parameter int MAX_SEG = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [ADDR_W-1:0] acc_src,
  input  logic [ADDR_W-1:0] acc_dst,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [ID_W-1:0]   acc_id,
  input  logic [PIDX_W-1:0] acc_slot,
  input  logic              push_ok,
  output logic              busy,
  output logic              push,
  output logic [ADDR_W-1:0] seg_src,
  output logic [ADDR_W-1:0] seg_dst,
  output logic [LEN_W-1:0]  seg_len,
  output logic [ID_W-1:0]   seg_id,
  output logic [PIDX_W-1:0] seg_slot
);
  localparam logic [LEN_W-1:0]  CAP = LEN_W'(MAX_SEG);
  localparam logic [ADDR_W-1:0] ADV = ADDR_W'(MAX_SEG);

  logic [LEN_W-1:0] rem;
  logic             last;

  assign last     = (rem <= CAP);
  assign seg_len  = last ? rem : CAP;
  assign push     = busy && push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rem      <= '0;
      seg_src  <= '0;
      seg_dst  <= '0;
      seg_id   <= '0;
      seg_slot <= '0;
    end else if (acc) begin
      busy     <= 1'b1;
      rem      <= acc_len;
      seg_src  <= acc_src;
      seg_dst  <= acc_dst;
      seg_id   <= acc_id;
      seg_slot <= acc_slot;
    end else if (push) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        rem     <= rem - CAP;
        seg_src <= seg_src + ADV;
        seg_dst <= seg_dst + ADV;
      end
    end
  end

  // R1
  split_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !busy);

  // R2
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !last) |=> (busy && rem == $past(rem) - CAP));
endmodule

// File: rtl/cq_seg_fifo.sv
module cq_seg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R1
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cq_parent_table.sv
module cq_parent_table #(
  parameter int PSLOTS = 4,
  parameter int LEN_W  = 32,
  parameter int TAG_W  = 4,
  parameter int ID_W   = 2,
  parameter int PIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ID_W-1:0]   alloc_id,
  output logic              free_ok,
  output logic [PIDX_W-1:0] free_idx,
  input  logic              retire,
  input  logic [PIDX_W-1:0] ret_idx,
  input  logic [LEN_W-1:0]  ret_len,
  output logic              cpl_valid,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [ID_W-1:0]   cpl_id,
  input  logic [TAG_W-1:0]  qry_tag,
  output logic              qry_hit,
  output logic [LEN_W-1:0]  qry_residue
);
  logic [PSLOTS-1:0] vld;
  logic [LEN_W-1:0]  res [PSLOTS];
  logic [TAG_W-1:0]  tg  [PSLOTS];
  logic [ID_W-1:0]   rid [PSLOTS];

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = PSLOTS-1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_ok  = 1'b1;
        free_idx = PIDX_W'(i);
      end
    end
  end

  always_comb begin
    qry_hit     = 1'b0;
    qry_residue = '0;
    for (int i = PSLOTS-1; i >= 0; i--) begin
      if (vld[i] && tg[i] == qry_tag) begin
        qry_hit     = 1'b1;
        qry_residue = res[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
      cpl_id    <= '0;
      for (int i = 0; i < PSLOTS; i++) begin
        res[i] <= '0;
        tg[i]  <= '0;
        rid[i] <= '0;
      end
    end else begin
      cpl_valid <= 1'b0;
      for (int i = 0; i < PSLOTS; i++) begin
        if (alloc && free_idx == PIDX_W'(i)) begin
          vld[i] <= 1'b1;
          res[i] <= alloc_len;
          tg[i]  <= alloc_tag;
          rid[i] <= alloc_id;
        end else if (retire && ret_idx == PIDX_W'(i)) begin
          res[i] <= res[i] - ret_len;
          if (res[i] == ret_len) vld[i] <= 1'b0;
        end
      end
      if (retire && res[ret_idx] == ret_len) begin
        cpl_valid <= 1'b1;
        cpl_tag   <= tg[ret_idx];
        cpl_id    <= rid[ret_idx];
      end
    end
  end

  // R3
  residue_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (vld[ret_idx] && ret_len <= res[ret_idx]));

  // R4
  cpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);

  // R1
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> free_ok);
endmodule

// File: rtl/cq_segmenter.sv
module cq_segmenter #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 32,
  parameter int TAG_W   = 4,
  parameter int NREQ    = 4,
  parameter int QDEPTH  = 8,
  parameter int PSLOTS  = 4,
  parameter int MAX_SEG = 32'h0FFF_FFFF,
  localparam int ID_W   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ID_W-1:0]   req_id,
  output logic              eng_start,
  output logic [ADDR_W-1:0] eng_src,
  output logic [ADDR_W-1:0] eng_dst,
  output logic [LEN_W-1:0]  eng_len,
  input  logic              eng_done,
  output logic              cpl_valid,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [ID_W-1:0]   cpl_id,
  input  logic [TAG_W-1:0]  qry_tag,
  output logic              qry_hit,
  output logic [LEN_W-1:0]  qry_residue,
  input  logic              drain_valid,
  input  logic [ID_W-1:0]   drain_id,
  output logic              drain_ack,
  output logic [NREQ-1:0]   active
);
  localparam int PIDX_W = (PSLOTS > 1) ? $clog2(PSLOTS) : 1;
  localparam int ENT_W  = 2*ADDR_W + LEN_W + PIDX_W + ID_W;
  localparam int CW     = $clog2(QDEPTH+1);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_SEG);

  logic              acc, sp_busy, sp_push;
  logic [ADDR_W-1:0] sp_src, sp_dst;
  logic [LEN_W-1:0]  sp_len;
  logic [ID_W-1:0]   sp_id;
  logic [PIDX_W-1:0] sp_slot, pt_free_idx, h_slot;
  logic [ID_W-1:0]   h_id;
  logic              pt_free_ok, f_empty, f_full, launched, pop;
  logic [CW-1:0]     f_count;
  logic [ENT_W-1:0]  f_head;
  logic              pend;
  logic [ID_W-1:0]   pend_id;

  assign req_ready = !sp_busy && pt_free_ok;
  assign acc       = req_valid && req_ready;
  assign pop       = eng_done && launched;
  assign eng_start = !f_empty && !launched;
  assign {eng_src, eng_dst, eng_len, h_slot, h_id} = f_head;

  cq_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W), .PIDX_W(PIDX_W),
                .MAX_SEG(MAX_SEG)) u_split (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_src(req_src), .acc_dst(req_dst),
    .acc_len(req_len), .acc_id(req_id), .acc_slot(pt_free_idx), .push_ok(!f_full),
    .busy(sp_busy), .push(sp_push), .seg_src(sp_src), .seg_dst(sp_dst),
    .seg_len(sp_len), .seg_id(sp_id), .seg_slot(sp_slot));

  cq_seg_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(sp_push),
    .din({sp_src, sp_dst, sp_len, sp_slot, sp_id}), .pop(pop), .dout(f_head),
    .empty(f_empty), .full(f_full), .count(f_count));

  cq_parent_table #(.PSLOTS(PSLOTS), .LEN_W(LEN_W), .TAG_W(TAG_W), .ID_W(ID_W),
                    .PIDX_W(PIDX_W)) u_par (
    .clk(clk), .rst_n(rst_n), .alloc(acc), .alloc_len(req_len), .alloc_tag(req_tag),
    .alloc_id(req_id), .free_ok(pt_free_ok), .free_idx(pt_free_idx),
    .retire(pop), .ret_idx(h_slot), .ret_len(eng_len),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_id(cpl_id),
    .qry_tag(qry_tag), .qry_hit(qry_hit), .qry_residue(qry_residue));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         launched <= 1'b0;
    else if (pop)       launched <= 1'b0;
    else if (eng_start) launched <= 1'b1;
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_act
    logic [CW-1:0] cnt;
    logic          inc, dec;
    assign inc = sp_push && sp_id == ID_W'(r);
    assign dec = pop && h_id == ID_W'(r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + CW'(inc) - CW'(dec);
    end
    assign active[r] = (cnt != '0) || (sp_busy && sp_id == ID_W'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_id   <= '0;
      drain_ack <= 1'b0;
    end else begin
      drain_ack <= 1'b0;
      if (drain_valid) begin
        pend    <= 1'b1;
        pend_id <= drain_id;
      end else if (pend && !active[pend_id]) begin
        pend      <= 1'b0;
        drain_ack <= 1'b1;
      end
    end
  end

  // R5
  empty_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_empty && sp_push) |=> eng_start);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R6
  next_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && f_count > CW'(1)) |=> eng_start);

  // R2
  seg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_len <= CAP);

  // R8
  active_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_empty && !sp_busy) |-> active == '0);
endmodule

// File: tb/cq_segmenter_bench.sv
module cq_segmenter_bench;
  localparam int AW = 12, LW = 8, TW = 4, NR = 4, QD = 4, PS = 2, MX = 5, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic [LW-1:0] req_len = '0;
  logic [TW-1:0] req_tag = '0;
  logic [IW-1:0] req_id = '0;
  logic eng_start, eng_done, man_done = 1'b0, auto_done = 1'b0;
  logic [AW-1:0] eng_src, eng_dst;
  logic [LW-1:0] eng_len;
  logic cpl_valid;
  logic [TW-1:0] cpl_tag;
  logic [IW-1:0] cpl_id;
  logic [TW-1:0] qry_tag = '0;
  logic qry_hit;
  logic [LW-1:0] qry_residue;
  logic drain_valid = 1'b0;
  logic [IW-1:0] drain_id = '0;
  logic drain_ack;
  logic [NR-1:0] active;

  assign eng_done = man_done | auto_done;
  always #10 clk = ~clk;

  cq_segmenter #(.ADDR_W(AW), .LEN_W(LW), .TAG_W(TW), .NREQ(NR), .QDEPTH(QD),
                 .PSLOTS(PS), .MAX_SEG(MX)) u_cq_segmenter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .req_tag(req_tag),
    .req_id(req_id), .eng_start(eng_start), .eng_src(eng_src), .eng_dst(eng_dst),
    .eng_len(eng_len), .eng_done(eng_done), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .cpl_id(cpl_id), .qry_tag(qry_tag), .qry_hit(qry_hit),
    .qry_residue(qry_residue), .drain_valid(drain_valid), .drain_id(drain_id),
    .drain_ack(drain_ack), .active(active));

  int total = 0, bad = 0;
  bit auto_eng = 1'b0, finished = 1'b0;
  logic [AW-1:0] xs_src [256];
  logic [AW-1:0] xs_dst [256];
  logic [LW-1:0] xs_len [256];
  logic [TW-1:0] xp_tag [64];
  logic [IW-1:0] xp_id  [64];
  int xp_cum [64];
  int xs_wr = 0, xs_rd = 0, xp_wr = 0, xp_rd = 0, n_done = 0, seg_total = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int id, input int tag, input int len, input logic [AW-1:0] src,
                      input logic [AW-1:0] dst);
    int nseg;
    nseg = (len == 0) ? 1 : (len + MX - 1) / MX;
    for (int k = 0; k < nseg; k++) begin
      xs_src[xs_wr] = src + AW'(k * MX);
      xs_dst[xs_wr] = dst + AW'(k * MX);
      xs_len[xs_wr] = LW'((len - k * MX > MX) ? MX : len - k * MX);
      xs_wr++;
    end
    seg_total += nseg;
    xp_tag[xp_wr] = TW'(tag);
    xp_id[xp_wr]  = IW'(id);
    xp_cum[xp_wr] = seg_total;
    xp_wr++;
    req_valid = 1'b1; req_id = IW'(id); req_tag = TW'(tag); req_len = LW'(len);
    req_src = src; req_dst = dst;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_done;
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    #1;
  endtask

  // engine model used during the sweep
  initial begin
    forever begin
      @(negedge clk);
      while (auto_eng && eng_start) begin
        chk("R2", "seg src", eng_src, xs_src[xs_rd]);
        chk("R2", "seg dst", eng_dst, xs_dst[xs_rd]);
        chk("R7", "seg len", eng_len, xs_len[xs_rd]);
        xs_rd++;
        repeat (1 + xs_rd % 3) @(negedge clk);
        auto_done = 1'b1;
        n_done++;
        @(negedge clk);
        auto_done = 1'b0;
        #1;
      end
    end
  end

  // completion monitor used during the sweep
  initial begin
    forever begin
      @(negedge clk);
      if (auto_eng && cpl_valid) begin
        chk("R4", "cpl tag", cpl_tag, xp_tag[xp_rd]);
        chk("R4", "cpl id", cpl_id, xp_id[xp_rd]);
        chk("R4", "dones before cpl", n_done, xp_cum[xp_rd]);
        xp_rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "ready", req_ready, 1);
    chk("R10", "start", eng_start, 0);
    chk("R10", "cpl", cpl_valid, 0);
    chk("R10", "active", active, 0);
    chk("R10", "hit", qry_hit, 0);
    chk("R10", "ack", drain_ack, 0);

    // long request, manual engine
    qry_tag = 4'd3;
    send(1, 3, 12, 12'h100, 12'h200);
    #1;
    chk("R1", "ready while splitting", req_ready, 0);
    chk("R3", "hit after accept", qry_hit, 1);
    chk("R3", "residue after accept", qry_residue, 12);
    @(negedge clk);
    chk("R5", "start", eng_start, 1);
    chk("R5", "src", eng_src, 12'h100);
    chk("R5", "dst", eng_dst, 12'h200);
    chk("R5", "len", eng_len, 5);
    chk("R8", "active1", active[1], 1);
    drain_valid = 1'b1; drain_id = 2'd1;
    @(negedge clk);
    drain_valid = 1'b0;
    chk("R5", "start pulse", eng_start, 0);
    repeat (2) @(negedge clk);
    chk("R9", "no ack while active", drain_ack, 0);
    chk("R1", "ready after split", req_ready, 1);
    pulse_done;
    chk("R4", "no early cpl", cpl_valid, 0);
    chk("R3", "residue 7", qry_residue, 7);
    chk("R6", "next start", eng_start, 1);
    chk("R6", "next src", eng_src, 12'h105);
    chk("R6", "next dst", eng_dst, 12'h205);
    chk("R6", "next len", eng_len, 5);
    @(negedge clk);
    pulse_done;
    chk("R3", "residue 2", qry_residue, 2);
    chk("R2", "tail src", eng_src, 12'h10A);
    chk("R2", "tail len", eng_len, 2);
    @(negedge clk);
    pulse_done;
    chk("R4", "cpl", cpl_valid, 1);
    chk("R4", "cpl tag", cpl_tag, 3);
    chk("R4", "cpl id", cpl_id, 1);
    chk("R3", "miss after cpl", qry_hit, 0);
    chk("R8", "active1 idle", active[1], 0);
    chk("R9", "ack not yet", drain_ack, 0);
    @(negedge clk);
    chk("R9", "ack", drain_ack, 1);
    chk("R4", "cpl one cycle", cpl_valid, 0);
    @(negedge clk);
    chk("R9", "ack one cycle", drain_ack, 0);

    // two small requests fill both parent slots
    send(2, 5, 1, 12'h300, 12'h310);
    send(3, 6, 1, 12'h320, 12'h330);
    repeat (2) @(negedge clk);
    chk("R1", "ready with slots full", req_ready, 0);
    chk("R7", "first head", eng_src, 12'h300);
    @(negedge clk);
    pulse_done;
    chk("R4", "cpl A", cpl_valid, 1);
    chk("R4", "cpl A tag", cpl_tag, 5);
    chk("R4", "cpl A id", cpl_id, 2);
    chk("R7", "second start", eng_start, 1);
    chk("R7", "second src", eng_src, 12'h320);
    chk("R1", "ready after slot free", req_ready, 1);
    @(negedge clk);
    pulse_done;
    chk("R4", "cpl B tag", cpl_tag, 6);
    chk("R4", "cpl B id", cpl_id, 3);

    // drain on an idle requester
    drain_valid = 1'b1; drain_id = 2'd0;
    @(negedge clk);
    drain_valid = 1'b0;
    chk("R9", "idle ack wait", drain_ack, 0);
    @(negedge clk);
    chk("R9", "idle ack", drain_ack, 1);

    // length sweep with automatic engine
    xs_wr = 0; xs_rd = 0; xp_wr = 0; xp_rd = 0; n_done = 0; seg_total = 0;
    auto_eng = 1'b1;
    for (int len = 0; len < 24; len++)
      send(len % NR, len % 16, len, AW'(len * 37), AW'(12'h800 + len * 53));
    for (int w = 0; w < 2000 && xp_rd < 24; w++) @(negedge clk);
    chk("R4", "all parents done", xp_rd, 24);
    chk("R2", "all segments started", xs_rd, xs_wr);
    chk("R8", "all idle", active, 0);
    chk("R1", "ready at end", req_ready, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule